// File: doc/BRIEF.md
# Interrupt Status and Mask Unit for a Two-Wire Bus Controller

This block gathers the five interrupt causes of a two-wire serial bus controller: transfer finished, transfer failed, buffer fault, receive queue nearly full and transmit queue nearly empty. Each cause latches into its own sticky bit of a raw status word. A mask word, written by software through its own strobe, selects which causes may raise the single interrupt line. Software reads the raw word, the mask, and a filtered view in which only enabled causes appear.

Software clears causes by writing ones to a clear word; zeros leave bits alone. The transmit-nearly-empty cause can also be cleared through a second, dedicated one-bit clear strobe, so a transmit refill routine can acknowledge it without touching the other causes. The two queue causes are level conditions: while the condition holds the bit is set again in every cycle, so a clear only sticks once the condition has dropped. When a cause arrives in the same cycle as a clear of its bit, the cause wins.

The interrupt line comes from a two-state controller, QUIET and RAISED. It moves QUIET to RAISED when any filtered bit is set (transition RAISE), and RAISED to QUIET when none is (transition DROP); otherwise it stays (HOLD). The line is high in RAISED, so it follows the filtered view with one cycle of delay. Address decoding and the logic producing the causes lie outside this block.

Top module: `irq_status_unit`

## Requirements
- R1: After `mask_we` is high in a cycle, `int_mask` equals the `mask_wdata` of that cycle from the next cycle on; a mask bit of 1 enables the cause at the same position.
- R2: Cause positions are fixed: bit 0 transfer finished, bit 1 transfer failed, bit 2 buffer fault, bit 3 receive nearly full, bit 4 transmit nearly empty; a cause high in a cycle makes its `raw_status` bit 1 in the next cycle.
- R3: A `clr_we` cycle clears every `raw_status` bit whose `clr_wdata` bit is 1; bits written with 0 are unchanged.
- R4: A latched bit stays 1 until it is cleared, whether or not its cause is still present.
- R5: When a cause and a clear of the same bit fall in one cycle, the bit is 1 afterwards.
- R6: The level causes (bits 3 and 4) set their bit in every cycle they are high, so a clear takes effect only in a cycle where the level is low.
- R7: A `txclr_we` cycle with `txclr_wdata` = 1 clears bit 4 only (subject to R5 and R6); with `txclr_wdata` = 0 it has no effect; bit 4 is also cleared by bit 4 of the shared clear.
- R8: `masked_status` always equals `raw_status` AND `int_mask`.
- R9: `irq` is registered: in each cycle it is 1 exactly when `masked_status` was non-zero in the previous cycle.
- R10: During and right after reset `raw_status`, `int_mask`, `masked_status` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done | input | 1 | Transfer-finished pulse (bit 0) |
| ev_xfer_err | input | 1 | Transfer-failed pulse (bit 1) |
| ev_fifo_err | input | 1 | Buffer-fault pulse (bit 2) |
| lvl_rx_full | input | 1 | Receive-nearly-full level (bit 3) |
| lvl_tx_empty | input | 1 | Transmit-nearly-empty level (bit 4) |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 5 | New mask value |
| clr_we | input | 1 | Shared clear write strobe |
| clr_wdata | input | 5 | Write-one-to-clear bits |
| txclr_we | input | 1 | Dedicated transmit clear strobe |
| txclr_wdata | input | 1 | Dedicated clear bit (1 clears bit 4) |
| raw_status | output | 5 | Latched causes |
| int_mask | output | 5 | Current mask |
| masked_status | output | 5 | Raw status filtered by mask |
| irq | output | 1 | Interrupt line |

## Verification
The function pair that can collide is latching a cause and clearing it: a pulse cause and a shared clear of the same bit are driven in one cycle, and a level cause is held high across several clear writes through both the shared and the dedicated paths. The bit is judged one cycle later at the ports; it must read 1 while the cause was present in the clear cycle and 0 only after a clear in a cycle with the cause low. The interrupt line is judged against the filtered view of the cycle before.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int NSRC       = 5;
    localparam int SRC_DONE   = 0;
    localparam int SRC_XERR   = 1;
    localparam int SRC_FERR   = 2;
    localparam int SRC_RX     = 3;
    localparam int SRC_TX     = 4;
    localparam int SRC_W      = $clog2(NSRC);

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/isr_bit.sv
module isr_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    logic q_next;

    // set has priority over clear
    always_comb begin
        q_next = q;
        if (clr_i) q_next = 1'b0;
        if (set_i) q_next = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_next;
    end
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED;  // RAISE
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;   // DROP
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_done,
    input  logic            ev_xfer_err,
    input  logic            ev_fifo_err,
    input  logic            lvl_rx_full,
    input  logic            lvl_tx_empty,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_wdata,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_wdata,
    input  logic            txclr_we,
    input  logic            txclr_wdata,
    output logic [NSRC-1:0] raw_status,
    output logic [NSRC-1:0] int_mask,
    output logic [NSRC-1:0] masked_status,
    output logic            irq
);
    src_vec_t set_vec;
    src_vec_t clr_vec;
    logic     tx_own_clr;

    always_comb begin
        set_vec           = '0;
        set_vec[SRC_DONE] = ev_done;
        set_vec[SRC_XERR] = ev_xfer_err;
        set_vec[SRC_FERR] = ev_fifo_err;
        set_vec[SRC_RX]   = lvl_rx_full;
        set_vec[SRC_TX]   = lvl_tx_empty;
    end

    assign tx_own_clr = txclr_we & txclr_wdata;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (i == SRC_TX) begin : g_dual
            assign clr_vec[i] = (clr_we & clr_wdata[i]) | tx_own_clr;
        end else begin : g_single
            assign clr_vec[i] = clr_we & clr_wdata[i];
        end
        isr_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .q     (raw_status[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       int_mask <= '0;
        else if (mask_we) int_mask <= mask_wdata;
    end

    assign masked_status = raw_status & int_mask;

    irq_line_fsm u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|masked_status),
        .irq     (irq)
    );
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
    import irq_status_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            ev_done,
    input logic            ev_xfer_err,
    input logic            ev_fifo_err,
    input logic            lvl_rx_full,
    input logic            lvl_tx_empty,
    input logic            mask_we,
    input logic [NSRC-1:0] mask_wdata,
    input logic            clr_we,
    input logic [NSRC-1:0] clr_wdata,
    input logic            txclr_we,
    input logic            txclr_wdata,
    input logic [NSRC-1:0] raw_status,
    input logic [NSRC-1:0] int_mask,
    input logic [NSRC-1:0] masked_status,
    input logic            irq
);
    logic [NSRC-1:0] sv;
    assign sv = {lvl_tx_empty, lvl_rx_full, ev_fifo_err, ev_xfer_err, ev_done};

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> int_mask == $past(mask_wdata)); // R1

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|sv) |=> ((raw_status & $past(sv)) == $past(sv))); // R5

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_status & $past(clr_wdata) & ~$past(sv)) == '0)); // R3

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && !txclr_we) |=> ((raw_status & $past(raw_status)) == $past(raw_status))); // R4

    AST_TX_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (txclr_we && txclr_wdata && !lvl_tx_empty) |=> !raw_status[SRC_TX]); // R7

    AST_TX_OWN_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        (txclr_we && !clr_we) |=>
            ((raw_status[SRC_TX-1:0] & $past(raw_status[SRC_TX-1:0])) == $past(raw_status[SRC_TX-1:0]))); // R7

    AST_MASKED_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        masked_status == (raw_status & int_mask)); // R8

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == (|$past(masked_status))); // R9
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (.*);

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ev = '0;
    logic       mask_we = 1'b0, clr_we = 1'b0, txclr_we = 1'b0, txclr_wdata = 1'b0;
    logic [4:0] mask_wdata = '0, clr_wdata = '0;
    logic [4:0] raw_status, int_mask, masked_status;
    logic       irq;
    int         n_chk = 0, n_bad = 0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_unit uut (
        .clk(clk), .rst_n(rst_n),
        .ev_done(ev[0]), .ev_xfer_err(ev[1]), .ev_fifo_err(ev[2]),
        .lvl_rx_full(ev[3]), .lvl_tx_empty(ev[4]),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .txclr_we(txclr_we), .txclr_wdata(txclr_wdata),
        .raw_status(raw_status), .int_mask(int_mask),
        .masked_status(masked_status), .irq(irq)
    );

    typedef struct packed {
        logic [4:0] ev;
        logic       cw;
        logic [4:0] cd;
        logic       tw;
        logic       td;
        logic       mw;
        logic [4:0] md;
        logic [4:0] xraw;
        logic [4:0] xmask;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{5'h00, 1'b0, 5'h00, 1'b0, 1'b0, 1'b1, 5'h1F, 5'h00, 5'h1F, 4'd1},  // R1 enable all
        '{5'h01, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 5'h00, 5'h01, 5'h1F, 4'd2},  // R2 bit0
        '{5'h02, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 5'h00, 5'h03, 5'h1F, 4'd4},  // R4 bit1, bit0 kept
        '{5'h04, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 5'h00, 5'h07, 5'h1F, 4'd2},  // R2 bit2
        '{5'h00, 1'b1, 5'h02, 1'b0, 1'b0, 1'b0, 5'h00, 5'h05, 5'h1F, 4'd3},  // R3 clear bit1
        '{5'h00, 1'b1, 5'h00, 1'b0, 1'b0, 1'b0, 5'h00, 5'h05, 5'h1F, 4'd3},  // R3 zeros no effect
        '{5'h01, 1'b1, 5'h01, 1'b0, 1'b0, 1'b0, 5'h00, 5'h05, 5'h1F, 4'd5},  // R5 set beats clear
        '{5'h08, 1'b1, 5'h08, 1'b0, 1'b0, 1'b0, 5'h00, 5'h0D, 5'h1F, 4'd5},  // R5 level + clear
        '{5'h08, 1'b1, 5'h08, 1'b0, 1'b0, 1'b0, 5'h00, 5'h0D, 5'h1F, 4'd6},  // R6 level still high
        '{5'h00, 1'b1, 5'h08, 1'b0, 1'b0, 1'b0, 5'h00, 5'h05, 5'h1F, 4'd6},  // R6 level gone
        '{5'h00, 1'b0, 5'h00, 1'b0, 1'b0, 1'b1, 5'h04, 5'h05, 5'h04, 4'd8},  // R8 partial mask
        '{5'h10, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 5'h00, 5'h15, 5'h04, 4'd2},  // R2 bit4
        '{5'h10, 1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 5'h00, 5'h15, 5'h04, 4'd7},  // R7 own clear, level high
        '{5'h00, 1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 5'h00, 5'h05, 5'h04, 4'd7},  // R7 own clear works
        '{5'h10, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 5'h00, 5'h15, 5'h04, 4'd6},  // R6 bit4 again
        '{5'h00, 1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 5'h00, 5'h15, 5'h04, 4'd7},  // R7 zero no effect
        '{5'h00, 1'b1, 5'h10, 1'b0, 1'b0, 1'b0, 5'h00, 5'h05, 5'h04, 4'd7},  // R7 shared path
        '{5'h00, 1'b1, 5'h05, 1'b0, 1'b0, 1'b0, 5'h00, 5'h00, 5'h04, 4'd3},  // R3 clear two
        '{5'h00, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 5'h00, 5'h00, 5'h04, 4'd9},  // R9 line drops
        '{5'h00, 1'b0, 5'h00, 1'b0, 1'b0, 1'b1, 5'h00, 5'h00, 5'h00, 4'd1}   // R1 disable all
    };

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ev = '0; mask_we = 0; clr_we = 0; txclr_we = 0;
        mask_wdata = '0; clr_wdata = '0; txclr_wdata = 0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic prev_pend;
        repeat (3) @(posedge clk);
        #1;
        check("R10 raw in reset", raw_status, 5'h00);
        check("R10 mask in reset", int_mask, 5'h00);
        check("R10 irq in reset", {4'b0, irq}, 5'h00);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R10 raw after reset", raw_status, 5'h00);
        check("R10 masked after reset", masked_status, 5'h00);
        prev_pend = 1'b0;

        for (int k = 0; k < NV; k++) begin
            ev = VEC[k].ev; clr_we = VEC[k].cw; clr_wdata = VEC[k].cd;
            txclr_we = VEC[k].tw; txclr_wdata = VEC[k].td;
            mask_we = VEC[k].mw; mask_wdata = VEC[k].md;
            @(posedge clk); #1;
            check($sformatf("R%0d raw v%0d", VEC[k].req, k), raw_status, VEC[k].xraw);
            check($sformatf("R%0d mask v%0d", VEC[k].req, k), int_mask, VEC[k].xmask);
            check($sformatf("R8 masked v%0d", k), masked_status, VEC[k].xraw & VEC[k].xmask);
            check($sformatf("R9 irq v%0d", k), {4'b0, irq}, {4'b0, prev_pend});
            prev_pend = |(VEC[k].xraw & VEC[k].xmask);
        end
        idle_inputs();

        // R8/R9: cause latches while masked, line stays low
        ev = 5'h02;
        @(posedge clk); #1;
        ev = '0;
        check("R8 raw set under zero mask", raw_status, 5'h02);
        check("R8 masked hidden", masked_status, 5'h00);
        @(posedge clk); #1;
        check("R9 irq stays low when masked", {4'b0, irq}, 5'h00);

        // R9: enabling the mask raises the line one cycle later
        mask_we = 1; mask_wdata = 5'h02;
        @(posedge clk); #1;
        mask_we = 0;
        check("R9 irq not yet high", {4'b0, irq}, 5'h00);
        @(posedge clk); #1;
        check("R9 irq high one cycle later", {4'b0, irq}, 5'h01);

        // R10: reset while bits are set
        ev = 5'h18;
        @(posedge clk); #1;
        rst_n = 0; ev = '0;
        @(posedge clk); #1;
        check("R10 raw after midrun reset", raw_status, 5'h00);
        check("R10 mask after midrun reset", int_mask, 5'h00);
        check("R10 irq after midrun reset", {4'b0, irq}, 5'h00);
        rst_n = 1;
        @(posedge clk); #1;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule